// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral guards a system against hung software. A prescaler turns the core clock into slow timing ticks. A 10-bit down-counter loses one count per tick, starting from a start value that software programs. Software proves it is alive by writing to a restart register, which reloads the counter. If the counter runs out once, the block raises a first-expiry flag and reloads itself. If it runs out again before software clears that flag, the block raises a second-expiry flag and requests a system reset.

A small register bus gives access to the restart, status, control, gate and start-value registers. Reads have no side effects. A stop bit freezes counting. It is set out of reset, so nothing counts until software clears it. A reboot-gate bit also comes up set, and while it is set the reset request is never driven.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the start-value register at offset 0x12 reads 0x0032, the control register at 0x08 reads 0x0800 (stop bit set), both status registers read 0, the gate register at 0x0C reads 1, and `rst_req` is low.
- R2: The register at 0x12 stores and returns all 16 bits written to it. Bits 9:0 are the start value, and every value up to 0x3FF is accepted.
- R3: A write of any data to offset 0x00 loads the counter with the start value and restarts the tick phase. A read of 0x00 returns the live count in bits 9:0, with zeros above.
- R4: While bit 11 of the control register at 0x08 is 1, the count does not change. Clearing the bit lets counting resume. The bit reads back as written, and the other control bits read 0.
- R5: While running, the count falls by one every TICK_DIV clock cycles, counted from the restart write.
- R6: A tick that finds the count at 0 while the first-expiry flag (bit 3 of 0x04) is clear sets that flag, reloads the count from the start value and does not request a reset.
- R7: A tick that finds the count at 0 while the first-expiry flag is set sets the second-expiry flag (bit 1 of 0x06) and reloads the count. If the gate bit is 0, it also drives `rst_req` high for exactly one clock, starting at the same edge.
- R8: While gate bit 0 of offset 0x0C is 1, `rst_req` stays low, and a second expiry still sets its flag. Writing 0 to the gate bit reads back as 0.
- R9: A status flag clears when 1 is written to its bit. Writing 0 leaves it unchanged.
- R10: Restart writes that arrive more often than every start+1 ticks keep the first-expiry flag clear.
- R11: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The hardest situation to reach is the second expiry. It needs the counter to run down twice with no restart in between and the first flag left uncleared. With the default prescaler this would take hours of clock, so the bench builds the block with a divide of 4 and a start value of 4. The second expiry then falls exactly 40 edges after a restart write. The bench runs this path once with the gate set and once with it cleared, samples around the exact edge, and counts how many cycles `rst_req` spends high.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_RESTART = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FIRST   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SECOND  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_GATE    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_START   = 5'h12;

  localparam int STOP_BIT   = 11;
  localparam int FIRST_BIT  = 3;
  localparam int SECOND_BIT = 1;
  localparam int GATE_BIT   = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RESTART,
    SEL_FIRST,
    SEL_SECOND,
    SEL_CTRL,
    SEL_GATE,
    SEL_START
  } reg_sel_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q, pre_d;
      logic          pre_en;

      assign tick = run && !restart && (pre_q == LAST);

      always_comb begin
        pre_en = 1'b1;
        if (!run || restart || tick) pre_d = '0;
        else                         pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W     = 10,
  parameter int START_RST = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && !load && at_zero;

  always_comb begin
    cnt_en = load || tick;
    cnt_d  = cnt_q;
    if (load)         cnt_d = start_val;
    else if (tick) begin
      if (at_zero)    cnt_d = start_val;
      else            cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(START_RST);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int START_RST = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output logic [CNT_W-1:0]  start_val,
  output logic              stop,
  output logic              restart_wr,
  output logic              gate,
  output logic              first_flag,
  output logic              second_flag,
  output logic              rst_req
);
  reg_sel_e          sel;
  logic              wr_en;
  logic [DATA_W-1:0] start_q, start_d;
  logic              stop_q, stop_d;
  logic              gate_q, gate_d;
  logic              first_q, first_d;
  logic              second_q, second_d;
  logic              rreq_q, rreq_d;
  logic              start_en, stop_en, gate_en, flag_en;

  always_comb begin
    unique case (bus_addr)
      OFS_RESTART: sel = SEL_RESTART;
      OFS_FIRST:   sel = SEL_FIRST;
      OFS_SECOND:  sel = SEL_SECOND;
      OFS_CTRL:    sel = SEL_CTRL;
      OFS_GATE:    sel = SEL_GATE;
      OFS_START:   sel = SEL_START;
      default:     sel = SEL_NONE;
    endcase
  end

  assign wr_en      = bus_sel && bus_wr;
  assign restart_wr = wr_en && (sel == SEL_RESTART);
  assign start_en   = wr_en && (sel == SEL_START);
  assign stop_en    = wr_en && (sel == SEL_CTRL);
  assign gate_en    = wr_en && (sel == SEL_GATE);
  assign flag_en    = 1'b1;

  always_comb begin
    start_d = bus_wdata;
    stop_d  = bus_wdata[STOP_BIT];
    gate_d  = bus_wdata[GATE_BIT];

    first_d  = first_q;
    second_d = second_q;
    if (wr_en && (sel == SEL_FIRST) && bus_wdata[FIRST_BIT])   first_d  = 1'b0;
    if (wr_en && (sel == SEL_SECOND) && bus_wdata[SECOND_BIT]) second_d = 1'b0;
    if (expire) begin
      first_d = 1'b1;
      if (first_q) second_d = 1'b1;
    end

    rreq_d = expire && first_q && !gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= DATA_W'(START_RST);
      stop_q   <= 1'b1;
      gate_q   <= 1'b1;
      first_q  <= 1'b0;
      second_q <= 1'b0;
      rreq_q   <= 1'b0;
    end else begin
      if (start_en) start_q <= start_d;
      if (stop_en)  stop_q  <= stop_d;
      if (gate_en)  gate_q  <= gate_d;
      if (flag_en) begin
        first_q  <= first_d;
        second_q <= second_d;
        rreq_q   <= rreq_d;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (sel)
        SEL_RESTART: bus_rdata[CNT_W-1:0] = cnt;
        SEL_FIRST:   bus_rdata[FIRST_BIT]  = first_q;
        SEL_SECOND:  bus_rdata[SECOND_BIT] = second_q;
        SEL_CTRL:    bus_rdata[STOP_BIT]   = stop_q;
        SEL_GATE:    bus_rdata[GATE_BIT]   = gate_q;
        SEL_START:   bus_rdata = start_q;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign start_val   = start_q[CNT_W-1:0];
  assign stop        = stop_q;
  assign gate        = gate_q;
  assign first_flag  = first_q;
  assign second_flag = second_q;
  assign rst_req     = rreq_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdt_pkg::*;
#(
  parameter int TICK_DIV  = 30_000_000,
  parameter int CNT_W     = 10,
  parameter int START_RST = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic             srst_n;
  logic             tick;
  logic             restart_wr;
  logic             stop;
  logic             gate;
  logic             first_flag;
  logic             second_flag;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] start_val;

  wdt_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (!stop),
    .restart (restart_wr),
    .tick    (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .START_RST(START_RST)) u_cnt (
    .clk       (clk),
    .rst_n     (srst_n),
    .tick      (tick),
    .load      (restart_wr),
    .start_val (start_val),
    .cnt       (cnt),
    .expire    (expire)
  );

  wdt_regs #(.CNT_W(CNT_W), .START_RST(START_RST)) u_regs (
    .clk         (clk),
    .rst_n       (srst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cnt         (cnt),
    .expire      (expire),
    .start_val   (start_val),
    .stop        (stop),
    .restart_wr  (restart_wr),
    .gate        (gate),
    .first_flag  (first_flag),
    .second_flag (second_flag),
    .rst_req     (rst_req)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             srst_n,
  input logic             restart_wr,
  input logic             stop,
  input logic [CNT_W-1:0] cnt,
  input logic             first_flag,
  input logic             second_flag,
  input logic             gate,
  input logic             rst_req
);
  // R4
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (stop && !restart_wr) |=> $stable(cnt));

  // R7
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> !rst_req);

  // R7
  second_after_first_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(second_flag) |-> $past(first_flag));

  // R8
  gate_blocks_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rst_req) |-> !$past(gate));

  // R6
  first_no_rst_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(first_flag) |-> !rst_req);

  // R7
  rst_sets_second_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> second_flag);
endmodule

bind wdog_two_stage wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .restart_wr  (restart_wr),
  .stop        (stop),
  .cnt         (cnt),
  .first_flag  (first_flag),
  .second_flag (second_flag),
  .gate        (gate),
  .rst_req     (rst_req)
);

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        rst_req;

  int checks;
  int errors;
  int rst_seen;
  bit done;

  wdog_two_stage #(.TICK_DIV(4), .CNT_W(10), .START_RST(50)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_req   (rst_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (rst_req === 1'b1) rst_seen++;

  // {req tag, write, offset, data, expected read}
  localparam int NV = 19;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {4'd2,  1'b1, 5'h12, 16'hA47F, 16'h0000},
    {4'd2,  1'b0, 5'h12, 16'h0000, 16'hA47F},
    {4'd2,  1'b1, 5'h12, 16'h03FF, 16'h0000},
    {4'd2,  1'b0, 5'h12, 16'h0000, 16'h03FF},
    {4'd2,  1'b1, 5'h12, 16'h0004, 16'h0000},
    {4'd2,  1'b0, 5'h12, 16'h0000, 16'h0004},
    {4'd4,  1'b1, 5'h08, 16'h0000, 16'h0000},
    {4'd4,  1'b0, 5'h08, 16'h0000, 16'h0000},
    {4'd4,  1'b1, 5'h08, 16'hFFFF, 16'h0000},
    {4'd4,  1'b0, 5'h08, 16'h0000, 16'h0800},
    {4'd8,  1'b1, 5'h0C, 16'h0000, 16'h0000},
    {4'd8,  1'b0, 5'h0C, 16'h0000, 16'h0000},
    {4'd8,  1'b1, 5'h0C, 16'h0001, 16'h0000},
    {4'd8,  1'b0, 5'h0C, 16'h0000, 16'h0001},
    {4'd11, 1'b0, 5'h02, 16'h0000, 16'h0000},
    {4'd11, 1'b1, 5'h02, 16'hFFFF, 16'h0000},
    {4'd11, 1'b0, 5'h02, 16'h0000, 16'h0000},
    {4'd11, 1'b1, 5'h1E, 16'hFFFF, 16'h0000},
    {4'd11, 1'b0, 5'h12, 16'h0000, 16'h0004}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd2:    tag = "R2";
      4'd4:    tag = "R4";
      4'd8:    tag = "R8";
      default: tag = "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(3);
  endtask

  task automatic check_reset_state();
    logic [15:0] v;
    bus_read(5'h12, v); chk("R1 start", v, 16'h0032);
    bus_read(5'h08, v); chk("R1 ctrl", v, 16'h0800);
    bus_read(5'h04, v); chk("R1 first", v, 16'h0000);
    bus_read(5'h06, v); chk("R1 second", v, 16'h0000);
    bus_read(5'h0C, v); chk("R1 gate", v, 16'h0001);
    chk("R1 rst_req", {15'd0, rst_req}, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int base;
    checks = 0; errors = 0; rst_seen = 0; done = 0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    do_reset();
    check_reset_state();

    // register vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) bus_write(VEC[i][36:32], VEC[i][31:16]);
      else begin
        bus_read(VEC[i][36:32], v);
        chk(tag(VEC[i][41:38]), v, VEC[i][15:0]);
      end
    end

    // R3 / R4: restart while stopped, count frozen
    bus_write(5'h00, 16'h0001);
    bus_read(5'h00, v); chk("R3 restart load", v, 16'h0004);
    edges(40);
    bus_read(5'h00, v); chk("R4 frozen while stopped", v, 16'h0004);

    // R5 / R6: run, count down, first expiry
    bus_write(5'h08, 16'h0000);
    bus_write(5'h00, 16'h0001);
    bus_read(5'h00, v); chk("R3 count after restart", v, 16'h0004);
    edges(4);  bus_read(5'h00, v); chk("R5 one tick", v, 16'h0003);
    edges(4);  bus_read(5'h00, v); chk("R5 two ticks", v, 16'h0002);
    edges(11); bus_read(5'h00, v); chk("R5 at zero", v, 16'h0000);
    bus_read(5'h04, v); chk("R6 not yet", v, 16'h0000);
    base = rst_seen;
    edges(1);
    bus_read(5'h04, v); chk("R6 first flag", v, 16'h0008);
    bus_read(5'h00, v); chk("R6 reloaded", v, 16'h0004);
    chk("R6 no reset", 16'(rst_seen - base), 16'h0000);

    // R4: stop mid-run
    bus_write(5'h08, 16'h0800);
    edges(20);
    bus_read(5'h00, v); chk("R4 stop mid-run", v, 16'h0004);

    // R9: write-one-to-clear
    bus_write(5'h04, 16'h0000);
    bus_read(5'h04, v); chk("R9 zero write keeps", v, 16'h0008);
    bus_write(5'h04, 16'h0008);
    bus_read(5'h04, v); chk("R9 one write clears", v, 16'h0000);

    // R10: frequent restarts
    bus_write(5'h08, 16'h0000);
    for (int k = 0; k < 5; k++) begin
      bus_write(5'h00, 16'h0001);
      edges(15);
    end
    bus_read(5'h04, v); chk("R10 kept alive", v, 16'h0000);

    // R8: second expiry with gate set
    base = rst_seen;
    bus_write(5'h00, 16'h0001);
    edges(40);
    bus_read(5'h06, v); chk("R8 second flag gated", v, 16'h0002);
    bus_write(5'h08, 16'h0800);
    chk("R8 no reset while gated", 16'(rst_seen - base), 16'h0000);

    // R7: second expiry with gate clear
    bus_write(5'h04, 16'h0008);
    bus_write(5'h06, 16'h0002);
    bus_read(5'h06, v); chk("R9 second cleared", v, 16'h0000);
    bus_write(5'h0C, 16'h0000);
    bus_read(5'h0C, v); chk("R8 gate clears", v, 16'h0000);
    bus_write(5'h08, 16'h0000);
    bus_write(5'h00, 16'h0001);
    base = rst_seen;
    edges(39);
    bus_read(5'h06, v); chk("R7 before second", v, 16'h0000);
    chk("R7 no early reset", {15'd0, rst_req}, 16'h0000);
    edges(1);
    bus_read(5'h06, v); chk("R7 second flag", v, 16'h0002);
    chk("R7 reset high", {15'd0, rst_req}, 16'h0001);
    edges(1);
    chk("R7 reset low again", {15'd0, rst_req}, 16'h0000);
    chk("R7 single pulse", 16'(rst_seen - base), 16'h0001);
    bus_write(5'h08, 16'h0800);

    // R2 / R3: largest start value
    bus_write(5'h12, 16'h03FF);
    bus_write(5'h00, 16'h0001);
    bus_read(5'h00, v); chk("R2 max start", v, 16'h03FF);

    // R1: reset again mid-use
    do_reset();
    check_reset_state();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule